// File: doc/BRIEF.md
# Neighbour-Scaled In-Place Array Update Pipeline

This block is a hard-wired streaming datapath that rewrites a run of 64-bit words held in a small on-chip memory. Every selected word becomes its own value plus twenty times the word directly above it, and the result is written back in place. The loop body that a general core would execute as six instructions per element is instead a fixed chain of stages. There is no fetch, no decode, no register file and no hazard logic, and the sequencing is a plain counter.

A host writes the array through a test port while the block is idle. It then pulses `startPulse` with a byte base address and an element count, and waits for `doneFlag`. The array is read back through the same test port. Once the pipeline is full, one element is finished per clock.

Top module: `nbr_scale_update`

## Requirements
- R1: For each updated word index k, the new value is old[k] + 20·old[k+1], taken modulo 2^64 in two's complement. The result is stored at index k.
- R2: With a byte base B and a count N, only word indices B/8 through B/8+N−1 are written. The three low bits of B are ignored. Every other word, including the neighbour at B/8+N, keeps its value.
- R3: Every neighbour read returns the value the word had before the run. The result therefore equals the loop run in ascending index order, with no stall cycles.
- R4: Let edge 0 be the clock edge that accepts a start with N>0. The last store happens at edge N+4 and `doneFlag` rises at edge N+5, so elements complete at one per cycle.
- R5: With N=0, `doneFlag` rises at edge 1 and no memory word changes.
- R6: A start pulse that arrives while a run is in progress is ignored, together with its base and count.
- R7: `doneFlag` is cleared at the edge that accepts a start. It then stays high from the end of that run until the next accepted start.
- R8: `tpRdData` shows the word at `tpRdAddr` without a clock delay. A test-port write lands at the next edge only when no run is in progress, and a write issued during a run is ignored.
- R9: Reset clears `doneFlag` and discards any run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| startPulse | input | 1 | Starts a run when the block is idle |
| baseAddr | input | IDX_W+3 | Byte address of the first element; the low 3 bits are ignored |
| elemCount | input | CNT_W | Number of elements to update |
| doneFlag | output | 1 | High from the end of a run until the next accepted start |
| tpWrEn | input | 1 | Test-port write strobe, honoured only while idle |
| tpWrAddr | input | IDX_W | Test-port write word index |
| tpWrData | input | 64 | Test-port write data |
| tpRdAddr | input | IDX_W | Test-port read word index |
| tpRdData | output | 64 | Word at tpRdAddr |

## Verification
The assertions take two things for granted. First, base/8 + count stays below the memory depth, so the neighbour of the last element never wraps onto a word already updated. Second, runs are separated by the idle phase in which the pipeline drains. The bench keeps every run inside the memory and waits for `doneFlag` before it touches memory again. It also deliberately injects a second start pulse and a test-port write in the middle of one run, so that it can show that both are dropped.

// File: rtl/nup_pkg.sv
package nup_pkg;
  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic busy;      // a run is in progress
    logic loadBase;  // accepted start: latch base word index
    logic issue;     // launch one element into the pipeline
  } nup_ctl_t;
endpackage

// File: rtl/nup_ctrl.sv
module nup_ctrl
  import nup_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startPulse,
  input  logic [CNT_W-1:0] elemCount,
  input  logic             pipeEmpty,
  output nup_ctl_t         ctl,
  output logic             doneFlag
);
  logic             busyQ;
  logic             doneQ;
  logic [CNT_W-1:0] remQ;
  logic             accept;
  logic             finish;

  assign accept       = startPulse && !busyQ;
  assign finish       = busyQ && (remQ == '0) && pipeEmpty;
  assign ctl.busy     = busyQ;
  assign ctl.loadBase = accept;
  assign ctl.issue    = busyQ && (remQ != '0);
  assign doneFlag     = doneQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busyQ <= 1'b0;
      doneQ <= 1'b0;
      remQ  <= '0;
    end else if (accept) begin
      busyQ <= 1'b1;
      doneQ <= 1'b0;
      remQ  <= elemCount;
    end else if (busyQ) begin
      if (ctl.issue) remQ <= remQ - 1'b1;
      if (finish) begin
        busyQ <= 1'b0;
        doneQ <= 1'b1;
      end
    end
  end

  // R6: a start seen mid-run must not reload the element counter
  p_busy_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busyQ && startPulse && remQ != '0) |=> (remQ == $past(remQ) - 1'b1));

  // R5: an empty request completes on the following edge
  p_zero_count_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (startPulse && !busyQ && elemCount == '0) |=> (remQ == '0 && busyQ) ##1 doneQ);

  // R4: completion is only reported once the datapath has drained
  p_done_pipe_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    doneQ |-> pipeEmpty);
endmodule

// File: rtl/nup_datapath.sv
module nup_datapath
  import nup_pkg::*;
#(
  parameter int             DATA_W = 64,
  parameter int             DEPTH  = 64,
  parameter int             IDX_W  = 6,
  parameter logic [DATA_W-1:0] SCALE = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  nup_ctl_t          ctl,
  input  logic [IDX_W-1:0]  baseIdx,
  input  logic              tpWrEn,
  input  logic [IDX_W-1:0]  tpWrAddr,
  input  logic [DATA_W-1:0] tpWrData,
  input  logic [IDX_W-1:0]  tpRdAddr,
  output logic [DATA_W-1:0] tpRdData,
  output logic              pipeEmpty
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  ptrQ;

  // stage valids and word indices: 0 addr, 1 load, 2 multiply, 3 add
  logic [3:0]        vld;
  logic [IDX_W-1:0]  idx [4];
  logic [DATA_W-1:0] curLd, nbrLd, curMul, prodMul, sumAdd;

  assign pipeEmpty = (vld == '0);
  assign tpRdData  = mem[tpRdAddr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptrQ <= '0;
      vld  <= '0;
    end else begin
      if (ctl.loadBase)   ptrQ <= baseIdx;
      else if (ctl.issue) ptrQ <= ptrQ + 1'b1;
      vld <= {vld[2:0], ctl.issue};
    end
  end

  always_ff @(posedge clk) begin
    idx[0]  <= ptrQ;
    idx[1]  <= idx[0];
    curLd   <= mem[idx[0]];
    nbrLd   <= mem[idx[0] + IDX_W'(1)];
    idx[2]  <= idx[1];
    curMul  <= curLd;
    prodMul <= nbrLd * SCALE;
    idx[3]  <= idx[2];
    sumAdd  <= curMul + prodMul;
  end

  // store stage has priority; the test port writes only while idle
  always_ff @(posedge clk) begin
    if (vld[3])                      mem[idx[3]] <= sumAdd;
    else if (tpWrEn && !ctl.busy)    mem[tpWrAddr] <= tpWrData;
  end

  // R4: consecutive elements in the load stage step by one word
  p_word_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vld[1] && $past(vld[1])) |-> (idx[1] == $past(idx[1]) + 1'b1));

  // R2: stores happen only inside a run announced by the sequencer
  p_store_in_run_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vld[3] |-> ctl.busy);
endmodule

// File: rtl/nbr_scale_update.sv
module nbr_scale_update
  import nup_pkg::*;
#(
  parameter int             DEPTH = 64,
  parameter logic [63:0]    SCALE = 64'd20,
  localparam int            IDX_W = $clog2(DEPTH),
  localparam int            CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             startPulse,
  input  logic [IDX_W+2:0] baseAddr,
  input  logic [CNT_W-1:0] elemCount,
  output logic             doneFlag,
  input  logic             tpWrEn,
  input  logic [IDX_W-1:0] tpWrAddr,
  input  logic [63:0]      tpWrData,
  input  logic [IDX_W-1:0] tpRdAddr,
  output logic [63:0]      tpRdData
);
  nup_ctl_t ctl;
  logic     pipeEmpty;

  nup_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .startPulse(startPulse), .elemCount(elemCount),
    .pipeEmpty(pipeEmpty), .ctl(ctl), .doneFlag(doneFlag)
  );

  nup_datapath #(.DATA_W(64), .DEPTH(DEPTH), .IDX_W(IDX_W), .SCALE(SCALE)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl), .baseIdx(baseAddr[IDX_W+2:3]),
    .tpWrEn(tpWrEn), .tpWrAddr(tpWrAddr), .tpWrData(tpWrData),
    .tpRdAddr(tpRdAddr), .tpRdData(tpRdData), .pipeEmpty(pipeEmpty)
  );
endmodule

// File: tb/tb_nbr_scale_update.sv
module tb_nbr_scale_update;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;
  localparam int IDX_W = 6;
  localparam int CNT_W = 7;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             startPulse = 1'b0;
  logic [IDX_W+2:0] baseAddr = '0;
  logic [CNT_W-1:0] elemCount = '0;
  logic             doneFlag;
  logic             tpWrEn = 1'b0;
  logic [IDX_W-1:0] tpWrAddr = '0;
  logic [63:0]      tpWrData = '0;
  logic [IDX_W-1:0] tpRdAddr = '0;
  logic [63:0]      tpRdData;

  int checks = 0;
  int errors = 0;

  typedef struct {
    int          idx;
    logic [63:0] exp;
    string       tag;
  } item_t;
  item_t expQ[$];
  logic [63:0] model [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  nbr_scale_update dut (
    .clk(clk), .rst_n(rst_n), .startPulse(startPulse), .baseAddr(baseAddr),
    .elemCount(elemCount), .doneFlag(doneFlag), .tpWrEn(tpWrEn),
    .tpWrAddr(tpWrAddr), .tpWrData(tpWrData), .tpRdAddr(tpRdAddr),
    .tpRdData(tpRdData)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expected words and compares them through the read port
  initial begin
    forever begin
      @(negedge clk);
      if (expQ.size() > 0) begin
        item_t it;
        it = expQ.pop_front();
        tpRdAddr = it.idx[IDX_W-1:0];
        #1;
        check($sformatf("%s word %0d", it.tag, it.idx), tpRdData, it.exp);
      end
    end
  end

  task automatic fill_mem(input int mode);
    for (int i = 0; i < DEPTH; i++) begin
      logic [63:0] v;
      if (mode == 0) v = {$urandom, $urandom};
      else v = (i % 2 == 1) ? 64'hFFFF_FFFF_FFFF_FFFF : 64'h7FFF_FFFF_FFFF_FFF0 + 64'(i);
      @(negedge clk);
      tpWrEn = 1'b1; tpWrAddr = IDX_W'(i); tpWrData = v;
      model[i] = v;
    end
    @(negedge clk);
    tpWrEn = 1'b0;
  endtask

  // driver: runs one pass and queues the expected memory image
  task automatic run(input int baseByte, input int n, input int mode, input bit inject,
                     input string inTag, input string outTag);
    int edges;
    int b;
    int expLat;
    logic [63:0] pre [DEPTH];
    fill_mem(mode);
    pre = model;
    b = baseByte >> 3;
    @(negedge clk);
    startPulse = 1'b1; baseAddr = (IDX_W+3)'(baseByte); elemCount = CNT_W'(n);
    @(posedge clk);
    @(negedge clk);
    startPulse = 1'b0;
    check("R7 done cleared at start", {63'd0, doneFlag}, 64'd0);
    if (inject) begin
      startPulse = 1'b1; baseAddr = '0; elemCount = CNT_W'(5);
      tpWrEn = 1'b1; tpWrAddr = IDX_W'(2); tpWrData = 64'hDEAD_BEEF_0000_0001;
    end
    edges = 0;
    do begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      startPulse = 1'b0;
      tpWrEn = 1'b0;
    end while (!doneFlag && edges < 500);
    expLat = (n == 0) ? 1 : n + 5;
    check(n == 0 ? "R5 done latency" : "R4 done latency", 64'(edges), 64'(expLat));
    for (int k = b; k < b + n; k++)
      model[k] = pre[k] + pre[k+1] * 64'd20;
    for (int i = 0; i < DEPTH; i++) begin
      item_t it;
      it.idx = i;
      it.exp = model[i];
      it.tag = (i >= b && i < b + n) ? inTag : outTag;
      expQ.push_back(it);
    end
    wait (expQ.size() == 0);
    @(negedge clk);
    check("R7 done held", {63'd0, doneFlag}, 64'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R4 watchdog expired actual=hang expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 done low in reset", {63'd0, doneFlag}, 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 done low after reset", {63'd0, doneFlag}, 64'd0);
    run(0, 10, 0, 1'b0, "R1", "R2");
    run(8*20 + 5, 30, 0, 1'b1, "R6", "R8");   // R2 low bits ignored, R6/R8 injection
    run(8*7, 0, 0, 1'b0, "R5", "R5");
    run(0, 63, 0, 1'b0, "R3", "R2");
    run(8*3, 40, 1, 1'b0, "R1 wrap", "R2");
    run(8*62, 1, 0, 1'b0, "R3 last", "R2");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule